// File: doc/BRIEF.md
# Cascaded Biquad Notch Filter

This block is a fixed-point infinite impulse response filter of even order, built as a series of second-order sections (biquads). The first section receives the input sample, each later section receives the output of the section before it, and the last section produces the filter output. A single-cycle strobe advances every section by one sample. There are no pipeline registers between sections. The whole chain settles combinationally within one clock period, and the result is registered once at the output.

Every section has five signed coefficients, and software can rewrite them at run time through an indexed write port. This lets the notch frequency, the quality factor or the filter family change without rebuilding the hardware. Writes go into a staging copy, and the staging copy becomes live only on a sample strobe. Because of this, no sample is ever computed from a mixture of old and new coefficient sets.

Top module: `notch_sos_chain`

## Requirements
- R1: While reset is asserted, `result_out` is 0 and `result_vld` is 0. Reset also clears every section's delay state. It loads every section as a pass-through: b0 is 1.0, which is 2^FRAC, and b1, b2, a1 and a2 are all zero.
- R2: `result_vld` is high in exactly the cycles that follow a cycle with `sample_stb` high.
- R3: Each section computes y = b0*x + b1*x[n-1] + b2*x[n-2] - a1*y[n-1] - a2*y[n-2]. The coefficients are two's complement with FRAC fractional bits. Section k takes its input from section k-1. The output of the last section appears on `result_out` one clock after the strobe.
- R4: Each section keeps the full precision of the products and the sum. It then adds 2^(FRAC-1) and shifts right arithmetically by FRAC, so halves round toward positive infinity.
- R5: Each section's result is saturated to the signed DW-bit range before it feeds the next section.
- R6: Section state and `result_out` change only on a strobe. Between strobes the output holds its value.
- R7: A write with `cfg_we` high stores `cfg_val` into section `cfg_sec`. `cfg_idx` selects the coefficient: 0 is b0, 1 is b1, 2 is b2, 3 is a1 and 4 is a2. A write with `cfg_idx` from 5 to 7, or with `cfg_sec` of ORDER/2 or more, is ignored.
- R8: A written coefficient is staged. The staging set is copied to the live set on the next strobe edge, and the sample taken on that strobe still uses the previous live set. The new value is therefore used from the second strobe after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sample_stb | input | 1 | Advances the chain by one sample |
| sample_in | input | DW | Signed input sample |
| result_out | output | DW | Signed filtered sample, registered |
| result_vld | output | 1 | High for one cycle after each strobe |
| cfg_we | input | 1 | Coefficient write enable |
| cfg_sec | input | clog2(ORDER/2+1) | Target section |
| cfg_idx | input | 3 | Coefficient select (0..4) |
| cfg_val | input | CW | Coefficient value, FRAC fractional bits |

## Verification
A corrupted delay register or coefficient stays hidden until the next strobe. It then shows on `result_out` one clock after that strobe. In recursive settings the error keeps recurring in later samples, because the a1 and a2 terms feed it back.

A fault in the staging logic shows one strobe early or one strobe late, at the sample where the coefficient set changes.

An out-of-range write that leaks into a real section changes that section's gain. The change becomes visible on the second strobe after the write.

// File: rtl/notch_pkg.sv
package notch_pkg;
  localparam int TAPS = 5;
  typedef enum logic [2:0] {
    CF_B0 = 3'd0,
    CF_B1 = 3'd1,
    CF_B2 = 3'd2,
    CF_A1 = 3'd3,
    CF_A2 = 3'd4
  } coef_sel_e;
endpackage

// File: rtl/notch_coef_bank.sv
module notch_coef_bank
  import notch_pkg::*;
#(
  parameter int NSEC = 2,
  parameter int CW   = 16,
  parameter int FRAC = 14,
  parameter int SECW = 2
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             commit,
  input  logic                             we,
  input  logic [SECW-1:0]                  sec,
  input  logic [2:0]                       idx,
  input  logic [CW-1:0]                    val,
  output logic [NSEC-1:0][TAPS-1:0][CW-1:0] stage,
  output logic [NSEC-1:0][TAPS-1:0][CW-1:0] live
);
  localparam logic [CW-1:0] UNITY = CW'(64'd1 << FRAC);

  logic [NSEC-1:0][TAPS-1:0][CW-1:0] stage_d, live_d;
  logic hit;

  assign hit = we && (32'(sec) < NSEC) && (idx <= 3'(CF_A2));

  always_comb begin
    stage_d = stage;
    if (hit) stage_d[sec][idx] = val;
    live_d = commit ? stage : live;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NSEC; s++) begin
        for (int t = 0; t < TAPS; t++) begin
          stage[s][t] <= (t == 0) ? UNITY : '0;
          live[s][t]  <= (t == 0) ? UNITY : '0;
        end
      end
    end else begin
      stage <= stage_d;
      live  <= live_d;
    end
  end
endmodule

// File: rtl/notch_biquad.sv
module notch_biquad
  import notch_pkg::*;
#(
  parameter int DW   = 16,
  parameter int CW   = 16,
  parameter int FRAC = 14
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       adv,
  input  logic signed [DW-1:0]       x_in,
  input  logic [TAPS-1:0][CW-1:0]    coef,
  output logic signed [DW-1:0]       y_out
);
  localparam int AW = DW + CW + 3;
  localparam logic signed [AW-1:0] RND  = AW'(64'sd1 <<< (FRAC - 1));
  localparam logic signed [AW-1:0] MAXV = AW'((64'sd1 <<< (DW - 1)) - 64'sd1);
  localparam logic signed [AW-1:0] MINV = AW'(-(64'sd1 <<< (DW - 1)));

  logic signed [DW-1:0] x1_q, x2_q, y1_q, y2_q;
  logic signed [DW-1:0] x1_d, x2_d, y1_d, y2_d;
  logic signed [AW-1:0] k [TAPS];
  logic signed [AW-1:0] acc, shr;

  always_comb begin
    for (int t = 0; t < TAPS; t++) k[t] = AW'($signed(coef[t]));
    acc = k[CF_B0] * AW'(x_in) + k[CF_B1] * AW'(x1_q) + k[CF_B2] * AW'(x2_q)
        - k[CF_A1] * AW'(y1_q) - k[CF_A2] * AW'(y2_q) + RND;
    shr = acc >>> FRAC;
    if (shr > MAXV)      y_out = MAXV[DW-1:0];
    else if (shr < MINV) y_out = MINV[DW-1:0];
    else                 y_out = shr[DW-1:0];
  end

  always_comb begin
    x1_d = x1_q;
    x2_d = x2_q;
    y1_d = y1_q;
    y2_d = y2_q;
    if (adv) begin
      x1_d = x_in;
      x2_d = x1_q;
      y1_d = y_out;
      y2_d = y1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x1_q <= '0;
      x2_q <= '0;
      y1_q <= '0;
      y2_q <= '0;
    end else begin
      x1_q <= x1_d;
      x2_q <= x2_d;
      y1_q <= y1_d;
      y2_q <= y2_d;
    end
  end
endmodule

// File: rtl/notch_sos_chain.sv
module notch_sos_chain
  import notch_pkg::*;
#(
  parameter int ORDER = 4,
  parameter int DW    = 16,
  parameter int CW    = 16,
  parameter int FRAC  = 14
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                sample_stb,
  input  logic signed [DW-1:0]                sample_in,
  output logic signed [DW-1:0]                result_out,
  output logic                                result_vld,
  input  logic                                cfg_we,
  input  logic [$clog2(ORDER/2+1)-1:0]        cfg_sec,
  input  logic [2:0]                          cfg_idx,
  input  logic [CW-1:0]                       cfg_val
);
  localparam int NSEC = ORDER / 2;
  localparam int SECW = $clog2(NSEC + 1);

  logic [NSEC-1:0][TAPS-1:0][CW-1:0] stage_w, live_w;
  logic signed [DW-1:0] link [NSEC+1];
  logic signed [DW-1:0] out_d;
  logic                 vld_d;

  notch_coef_bank #(
    .NSEC(NSEC), .CW(CW), .FRAC(FRAC), .SECW(SECW)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .commit(sample_stb),
    .we(cfg_we), .sec(cfg_sec), .idx(cfg_idx), .val(cfg_val),
    .stage(stage_w), .live(live_w)
  );

  assign link[0] = sample_in;

  for (genvar g = 0; g < NSEC; g++) begin : g_sec
    notch_biquad #(.DW(DW), .CW(CW), .FRAC(FRAC)) u_bq (
      .clk(clk), .rst_n(rst_n), .adv(sample_stb),
      .x_in(link[g]), .coef(live_w[g]), .y_out(link[g+1])
    );
  end

  always_comb begin
    out_d = sample_stb ? link[NSEC] : result_out;
    vld_d = sample_stb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_out <= '0;
      result_vld <= 1'b0;
    end else begin
      result_out <= out_d;
      result_vld <= vld_d;
    end
  end
endmodule

// File: rtl/notch_sos_chain_chk.sv
module notch_sos_chain_chk
  import notch_pkg::*;
#(
  parameter int ORDER = 4,
  parameter int DW    = 16,
  parameter int CW    = 16,
  parameter int NSEC  = ORDER / 2,
  parameter int SECW  = $clog2(NSEC + 1)
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic                              sample_stb,
  input logic                              result_vld,
  input logic [DW-1:0]                     result_out,
  input logic                              cfg_we,
  input logic [SECW-1:0]                   cfg_sec,
  input logic [2:0]                        cfg_idx,
  input logic [NSEC-1:0][TAPS-1:0][CW-1:0] stage,
  input logic [NSEC-1:0][TAPS-1:0][CW-1:0] live
);
  AST_VLD_AFTER_STB: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> result_vld); // R2
  AST_NO_VLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_stb |=> !result_vld); // R2
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_stb |=> $stable(result_out)); // R6
  AST_LIVE_ON_STB: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_stb |=> $stable(live)); // R8
  AST_STAGE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_we || cfg_idx > 3'd4 || 32'(cfg_sec) >= NSEC) |=> $stable(stage)); // R7
endmodule

bind notch_sos_chain notch_sos_chain_chk #(
  .ORDER(ORDER), .DW(DW), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb), .result_vld(result_vld),
  .result_out(result_out), .cfg_we(cfg_we), .cfg_sec(cfg_sec), .cfg_idx(cfg_idx),
  .stage(stage_w), .live(live_w)
);

// File: tb/tb_notch_sos_chain.sv
module tb_notch_sos_chain;
  localparam int ORDER = 4;
  localparam int DW = 16;
  localparam int CW = 16;
  localparam int FRAC = 14;
  localparam int NS = ORDER / 2;
  localparam int SECW = $clog2(NS + 1);
  localparam int CLK_PERIOD = 10;
  localparam longint SMAX = (64'sd1 <<< (DW - 1)) - 1;
  localparam longint SMIN = -(64'sd1 <<< (DW - 1));

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sample_stb = 1'b0;
  logic signed [DW-1:0] sample_in = '0;
  logic signed [DW-1:0] result_out;
  logic result_vld;
  logic cfg_we = 1'b0;
  logic [SECW-1:0] cfg_sec = '0;
  logic [2:0] cfg_idx = '0;
  logic [CW-1:0] cfg_val = '0;

  int nchk = 0, nbad = 0;
  bit finished = 0;
  logic signed [DW-1:0] expq[$];
  logic signed [DW-1:0] last_out = '0;
  logic stb_d = 1'b0;
  string tag = "R3";

  longint ml[NS][5], ms[NS][5];
  longint mx1[NS], mx2[NS], my1[NS], my2[NS];

  notch_sos_chain #(.ORDER(ORDER), .DW(DW), .CW(CW), .FRAC(FRAC)) dut (
    .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb), .sample_in(sample_in),
    .result_out(result_out), .result_vld(result_vld), .cfg_we(cfg_we),
    .cfg_sec(cfg_sec), .cfg_idx(cfg_idx), .cfg_val(cfg_val)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, longint got, longint exp);
    nchk++;
    if (got != exp) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
    end
  endtask

  // R1: reset model: pass-through coefficients, cleared state
  task automatic model_reset();
    for (int s = 0; s < NS; s++) begin
      for (int t = 0; t < 5; t++) begin
        ml[s][t] = (t == 0) ? (64'sd1 <<< FRAC) : 0;
        ms[s][t] = ml[s][t];
      end
      mx1[s] = 0; mx2[s] = 0; my1[s] = 0; my2[s] = 0;
    end
  endtask

  // R3 R4 R5 R8: one sample through the model
  function automatic longint model_step(longint x);
    longint v = x;
    for (int s = 0; s < NS; s++) begin
      longint acc, y;
      acc = ml[s][0]*v + ml[s][1]*mx1[s] + ml[s][2]*mx2[s]
          - ml[s][3]*my1[s] - ml[s][4]*my2[s] + (64'sd1 <<< (FRAC - 1));
      y = acc >>> FRAC;
      if (y > SMAX) y = SMAX;
      if (y < SMIN) y = SMIN;
      mx2[s] = mx1[s]; mx1[s] = v;
      my2[s] = my1[s]; my1[s] = y;
      v = y;
    end
    for (int s = 0; s < NS; s++)
      for (int t = 0; t < 5; t++) ml[s][t] = ms[s][t];
    return v;
  endfunction

  task automatic write_coef(int sec, int idx, longint val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sec = SECW'(sec); cfg_idx = 3'(idx); cfg_val = CW'(val);
    // R7: only in-range section and index land in staging
    if (sec < NS && idx < 5) ms[sec][idx] = val;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send(longint x, int gap);
    @(negedge clk);
    sample_in = DW'(x);
    sample_stb = 1'b1;
    expq.push_back(DW'(model_step(x)));
    @(negedge clk);
    sample_stb = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic drain();
    int n = 0;
    while (expq.size() != 0 && n < 50) begin @(negedge clk); n++; end
    repeat (2) @(negedge clk);
  endtask

  always @(posedge clk) stb_d <= sample_stb;

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (result_vld !== stb_d) check("R2 vld", longint'(result_vld), longint'(stb_d));
      if (result_vld) begin
        if (expq.size() == 0) check("R2 unexpected vld", 1, 0);
        else check(tag, longint'(result_out), longint'(expq.pop_front()));
        last_out = result_out;
      end else if (result_out !== last_out) begin
        check("R6 hold", longint'(result_out), longint'(last_out));
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nbad++;
    nchk++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    check("R1 reset out", longint'(result_out), 0);
    check("R1 reset vld", longint'(result_vld), 0);
    rst_n = 1'b1;

    // R1 R3: pass-through after reset
    tag = "R1 pass";
    send(100, 0); send(-200, 1); send(32767, 2); send(-32768, 0); send(7, 3);
    drain();

    // R8: first strobe after the write still uses old set; R4 rounding
    tag = "R8/R4";
    write_coef(0, 0, 8192);
    send(1, 1); send(1, 1); send(-1, 0); send(3, 2); send(-3, 0); send(5, 1);
    drain();

    // R3: recursive section feeding an averaging section
    tag = "R3 cascade";
    write_coef(0, 0, 16384); write_coef(0, 3, -8192);
    write_coef(1, 0, 8192);  write_coef(1, 1, 8192);
    send(0, 0);
    send(1000, 1);
    for (int i = 0; i < 8; i++) send(0, i % 3);
    send(-777, 0);
    drain();

    // R5: saturation in the first section
    tag = "R5 sat";
    write_coef(0, 0, 32767); write_coef(0, 3, 0);
    write_coef(1, 0, 16384); write_coef(1, 1, 0);
    send(0, 0);
    send(30000, 1); send(-30000, 0); send(20000, 1); send(-20000, 0); send(100, 0);
    drain();

    // R7: ignored writes (section out of range, index 5..7)
    tag = "R7 ignored";
    write_coef(2, 0, 0); write_coef(3, 0, 0);
    write_coef(0, 5, 0); write_coef(0, 6, 1234); write_coef(1, 7, 0);
    send(1000, 0); send(-1000, 1); send(2000, 0);
    drain();

    // R3: notch at a quarter of the sample rate
    tag = "R3 notch";
    write_coef(0, 0, 15565); write_coef(0, 1, 0); write_coef(0, 2, 15565);
    write_coef(0, 3, 0); write_coef(0, 4, 14746);
    send(0, 0);
    for (int i = 0; i < 40; i++) begin
      case (i % 4)
        0: send(0, 0);
        1: send(10000, 0);
        2: send(0, 1);
        default: send(-10000, 0);
      endcase
    end
    drain();

    // R1: reset in mid-run clears state and restores pass-through
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid reset out", longint'(result_out), 0);
    check("R1 mid reset vld", longint'(result_vld), 0);
    model_reset();
    last_out = '0;
    rst_n = 1'b1;
    tag = "R1 after reset";
    send(4321, 0); send(-55, 2); send(0, 0);
    drain();

    check("R2 queue empty", longint'(expq.size()), 0);
    finish_run();
  end
endmodule